// File: doc/BRIEF.md
# TDM Serial Input Sampler with Fractional Bit Delay

This block recovers the channels of one time-division-multiplexed serial input stream. It runs on a fast clock at sixteen times the serial bit rate. A single-cycle frame pulse on that clock marks the first fast-clock cycle of bit 7 of channel 0. A frame holds `N_CHAN` eight-bit channels, 128 by default. Each channel arrives most significant bit first.

The sampling point inside each bit period is set by two controls:
- A 5-bit delay code moves the sampling point later in quarter-bit steps. One quarter bit is 4 fast-clock cycles.
- A sampling-mode input picks the late point (3/4 of the bit, 12 cycles) or the middle point (2/4 of the bit, 8 cycles).

The two offsets add up, so the first sample of a frame is taken `4*D + 12` or `4*D + 8` edges after the frame-pulse edge. Offsets longer than one bit simply push the whole frame later. Both controls are read only on the frame-pulse edge.

Alignment is handled by a four-state controller:
- `ST_IDLE`: no frame pulse has been seen since reset. A pulse moves it to `ST_FIRST`.
- `ST_FIRST`: counts down the offset with the bit engine stopped. When the count expires, the controller issues a realign and enters `ST_RUN`.
- `ST_RUN`: the bit engine runs freely. A pulse moves it to `ST_REALIGN`.
- `ST_REALIGN`: counts down the new offset while the old alignment keeps sampling. When the count expires, a realign returns it to `ST_RUN`.

A pulse that arrives during either countdown reloads the counter and leaves the state unchanged.

For each completed byte, the block raises a one-cycle strobe together with the channel number and the byte.

Top module: `tdm_sampler`

## Requirements
- R1: While reset is asserted, `chan_o`, `byte_o` and `byte_vld_o` are all zero.
- R2: With `late_sample_i` high and delay code D latched at a frame pulse, bit k of that frame (k counted from 0) is captured on the clock edge `4*D + 12 + 16*k` after the frame-pulse edge.
- R3: With `late_sample_i` low, the capture edge of bit k is `4*D + 8 + 16*k` after the frame-pulse edge.
- R4: The first bit captured for a channel becomes `byte_o[7]` and the eighth becomes `byte_o[0]`, so the most significant bit arrives first.
- R5: `byte_vld_o` is high for exactly one cycle, in the cycle after the edge that captures the eighth bit of a channel. It is low at every other time.
- R6: `chan_o` gives the channel index of the byte being presented. The index counts 0 to `N_CHAN-1` and then continues at 0 with no gap.
- R7: Offsets longer than one bit carry into later bit positions. With D = 31 and the late point, the first capture comes 136 edges after the pulse and still holds bit 7 of channel 0.
- R8: The delay code and the sampling mode are read only on the frame-pulse edge. Changes at other times have no effect until the next pulse.
- R9: After a frame pulse, capture keeps the old alignment until the new offset expires. The capture at that point is bit 7 of channel 0, and any partly collected byte is discarded.
- R10: No byte strobe occurs after reset until a frame pulse has been received and its offset has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse_i | input | 1 | Single-cycle frame start marker |
| ser_i | input | 1 | Serial TDM data |
| delay_code_i | input | DLY_W (5) | Input bit delay in quarter-bit steps |
| late_sample_i | input | 1 | 1: sample at the 3/4 point, 0: sample at the 2/4 point |
| chan_o | output | $clog2(N_CHAN) (7) | Channel index of the presented byte |
| byte_o | output | BYTE_W (8) | Received channel byte |
| byte_vld_o | output | 1 | One-cycle byte strobe |

## Verification
The assertions assume that `frame_pulse_i` is high for a single fast-clock cycle. They also assume that successive pulses are farther apart than the largest offset, 136 cycles, so a countdown never overlaps the next pulse. The one-cycle strobe and sample-spacing properties further rely on `OVS` being at least 2 and `BYTE_W` at least 2. The stimulus raises the pulse for one cycle every 512 cycles, which is one full four-channel frame. Controls change mid-frame only, never on a pulse edge. Serial data is held at the intended bit value only on the exact capture edge and carries a pseudo-random pattern on every other edge, so any shift in the sampling point corrupts the received bytes.

// File: rtl/tdm_smp_pkg.sv
package tdm_smp_pkg;

    // Alignment controller states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,  // no frame pulse since reset
        ST_FIRST   = 2'd1,  // counting down offset, engine stopped
        ST_RUN     = 2'd2,  // engine free-running
        ST_REALIGN = 2'd3   // counting down new offset, engine still running
    } algn_state_t;

endpackage

// File: rtl/tdm_smp_align.sv
module tdm_smp_align
    import tdm_smp_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic             run_o,
    output logic             realign_o
);

    algn_state_t      state_q, state_d;
    logic [OFS_W-1:0] cnt_q;
    logic             counting;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Offset countdown, loaded only on the frame pulse (delay/mode read there)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (frame_pulse_i)   cnt_q <= ofs_i - OFS_W'(1);
        else if (cnt_q != '0)     cnt_q <= cnt_q - OFS_W'(1);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (frame_pulse_i) state_d = ST_FIRST;
            ST_FIRST:   if (!frame_pulse_i && cnt_q == '0) state_d = ST_RUN;
            ST_RUN:     if (frame_pulse_i) state_d = ST_REALIGN;
            ST_REALIGN: if (!frame_pulse_i && cnt_q == '0) state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        counting  = (state_q == ST_FIRST) || (state_q == ST_REALIGN);
        realign_o = counting && !frame_pulse_i && (cnt_q == '0);
        run_o     = (state_q == ST_RUN) || (state_q == ST_REALIGN);
    end

    // R10: without a pulse the controller stays idle
    a_r10_idle_until_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !frame_pulse_i) |=> (state_q == ST_IDLE));

    // R8: between pulses the countdown only decrements, state held
    a_r8_count_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !frame_pulse_i && cnt_q != '0) |=>
            (cnt_q == $past(cnt_q) - OFS_W'(1)) && $stable(state_q));

endmodule

// File: rtl/tdm_smp_engine.sv
module tdm_smp_engine #(
    parameter int OVS        = 16,
    parameter int FRAME_BITS = 1024,
    parameter int BIT_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             realign_i,
    output logic             samp_o,
    output logic [BIT_W-1:0] bidx_o
);

    localparam int PH_W = $clog2(OVS);

    logic [PH_W-1:0]  ph_q;
    logic [BIT_W-1:0] bcnt_q;

    always_comb begin
        samp_o = realign_i || (run_i && ph_q == '0);
        bidx_o = realign_i ? '0 : bcnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= '0;
            bcnt_q <= '0;
        end else if (samp_o) begin
            ph_q   <= PH_W'(OVS - 1);
            bcnt_q <= (bidx_o == BIT_W'(FRAME_BITS - 1)) ? '0 : bidx_o + BIT_W'(1);
        end else if (run_i) begin
            ph_q   <= ph_q - PH_W'(1);
        end
    end

    // R4: captures are never on adjacent edges
    a_r4_bit_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        samp_o |=> !samp_o);

endmodule

// File: rtl/tdm_smp_assemble.sv
module tdm_smp_assemble #(
    parameter int BYTE_W = 8,
    parameter int BIT_W  = 10,
    parameter int CHAN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_i,
    input  logic [BIT_W-1:0]  bidx_i,
    input  logic              ser_i,
    output logic [CHAN_W-1:0] chan_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              vld_o
);

    localparam int LB_W = $clog2(BYTE_W);

    logic [BYTE_W-2:0] sh_q;
    logic              last_bit;

    always_comb last_bit = samp_i && (bidx_i[LB_W-1:0] == LB_W'(BYTE_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            chan_o <= '0;
            byte_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= last_bit;
            if (samp_i) sh_q <= {sh_q[BYTE_W-3:0], ser_i};
            if (last_bit) begin
                byte_o <= {sh_q, ser_i};
                chan_o <= CHAN_W'(bidx_i[BIT_W-1:LB_W]);
            end
        end
    end

    // R5: strobe lasts one cycle
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);

endmodule

// File: rtl/tdm_sampler.sv
module tdm_sampler #(
    parameter int N_CHAN = 128,
    parameter int BYTE_W = 8,
    parameter int OVS    = 16,
    parameter int DLY_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_pulse_i,
    input  logic                      ser_i,
    input  logic [DLY_W-1:0]          delay_code_i,
    input  logic                      late_sample_i,
    output logic [$clog2(N_CHAN)-1:0] chan_o,
    output logic [BYTE_W-1:0]         byte_o,
    output logic                      byte_vld_o
);

    localparam int QTR        = OVS / 4;
    localparam int MAX_OFS    = ((1 << DLY_W) - 1) * QTR + 3 * QTR;
    localparam int OFS_W      = $clog2(MAX_OFS + 1);
    localparam int FRAME_BITS = N_CHAN * BYTE_W;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int CHAN_W     = $clog2(N_CHAN);

    logic [OFS_W-1:0] ofs_now;
    logic             run, realign, samp;
    logic [BIT_W-1:0] bidx;
    logic             wait_first_q;

    // Offset from the pulse edge to the first capture
    always_comb ofs_now = OFS_W'(delay_code_i) * OFS_W'(QTR)
                        + (late_sample_i ? OFS_W'(3 * QTR) : OFS_W'(2 * QTR));

    tdm_smp_align #(.OFS_W(OFS_W)) align_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_pulse_i (frame_pulse_i),
        .ofs_i         (ofs_now),
        .run_o         (run),
        .realign_o     (realign)
    );

    tdm_smp_engine #(.OVS(OVS), .FRAME_BITS(FRAME_BITS), .BIT_W(BIT_W)) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .realign_i (realign),
        .samp_o    (samp),
        .bidx_o    (bidx)
    );

    tdm_smp_assemble #(.BYTE_W(BYTE_W), .BIT_W(BIT_W), .CHAN_W(CHAN_W)) asm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .samp_i (samp),
        .bidx_i (bidx),
        .ser_i  (ser_i),
        .chan_o (chan_o),
        .byte_o (byte_o),
        .vld_o  (byte_vld_o)
    );

    // Checker state: a realign has happened and its first byte is pending
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wait_first_q <= 1'b0;
        else if (realign)    wait_first_q <= 1'b1;
        else if (byte_vld_o) wait_first_q <= 1'b0;
    end

    // R9: the realign capture never completes a byte
    a_r9_no_byte_on_realign: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> !byte_vld_o);

    // R6: first byte after an alignment is channel 0
    a_r6_chan0_after_align: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_o && wait_first_q) |-> (chan_o == '0));

    // R10: nothing captured while neither running nor aligning
    a_r10_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !realign) |=> !byte_vld_o);

endmodule

// File: tb/tdm_sampler_tb_top.sv
module tdm_sampler_tb_top;

    localparam int NCH   = 4;
    localparam int BW    = 8;
    localparam int OVS   = 16;
    localparam int FRAME = NCH * BW * OVS;
    localparam int NEVER = 32'h7fff_ffff;
    localparam int NVEC  = 8;

    // delay code, late flag, expected offset to first capture
    localparam int VT [NVEC][3] = '{
        '{0, 1, 12}, '{0, 0, 8}, '{3, 1, 24}, '{3, 0, 20},
        '{31, 1, 136}, '{31, 0, 132}, '{1, 1, 16}, '{16, 0, 72}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp = 1'b0;
    logic       ser = 1'b0;
    logic [4:0] dly = '0;
    logic       late = 1'b1;
    logic [1:0] chan_o;
    logic [7:0] byte_o;
    logic       byte_vld_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    tdm_sampler #(.N_CHAN(NCH)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_pulse_i (fp),
        .ser_i         (ser),
        .delay_code_i  (dly),
        .late_sample_i (late),
        .chan_o        (chan_o),
        .byte_o        (byte_o),
        .byte_vld_o    (byte_vld_o)
    );

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic logic [7:0] pat(input int fr, input int ch, input int salt);
        return 8'((fr * 83 + ch * 29 + salt * 17 + 165) & 255);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        fp    = 1'b0;
        ser   = 1'b0;
        repeat (3) @(negedge clk);
        chk(byte_vld_o == 1'b0 && chan_o == '0 && byte_o == '0,
            $sformatf("R1 reset outputs act=%0b/%0d/%0h exp=0/0/0",
                      byte_vld_o, chan_o, byte_o));
        rst_n = 1'b1;
    endtask

    task automatic run_seq(input int nfr, input int len,
                           input int da, input int ha, input int oa,
                           input int chg, input int db, input int hb, input int ob,
                           input int salt, input string tag);
        int cur_r = 0, cur_f = 0, pend_r = 0, pend_f = 0;
        bit have_cur = 0, have_pend = 0;
        bit ev = 0;
        int ec = 0;
        logic [7:0] eb = '0;
        int seen = 0, want = 0;
        for (int j = 0; j <= len; j++) begin
            @(negedge clk);
            // outputs of edge j-1
            if (byte_vld_o) seen++;
            if (ev || byte_vld_o) begin
                chk(byte_vld_o == ev, $sformatf("R5 %s strobe at edge %0d act=%0b exp=%0b",
                                                tag, j - 1, byte_vld_o, ev));
                if (ev && byte_vld_o) begin
                    chk(int'(chan_o) == ec, $sformatf("R6 %s channel act=%0d exp=%0d",
                                                      tag, chan_o, ec));
                    chk(byte_o == eb, $sformatf("R4 %s byte ch%0d act=%0h exp=%0h",
                                                tag, ec, byte_o, eb));
                end
            end
            if (j == len) break;
            // inputs for edge j
            if (have_pend && j >= pend_r) begin
                cur_r = pend_r; cur_f = pend_f; have_cur = 1; have_pend = 0;
            end
            fp   = (nfr > 0) && (j % FRAME == 0) && (j / FRAME < nfr);
            dly  = (j >= chg) ? 5'(db) : 5'(da);
            late = (j >= chg) ? hb[0] : ha[0];
            if (fp) begin
                pend_r = j + ((j >= chg) ? ob : oa);
                pend_f = j / FRAME;
                have_pend = 1;
            end
            ev  = 0;
            ser = 1'(((j * 5) ^ (j >> 2)) & 1);
            if (have_cur && ((j - cur_r) % OVS) == 0) begin
                int g, ch, fr;
                logic [7:0] b;
                g   = (j - cur_r) / OVS;
                ch  = (g / BW) % NCH;
                fr  = cur_f + g / (BW * NCH);
                b   = pat(fr, ch, salt);
                ser = b[7 - (g % BW)];
                if (g % BW == BW - 1) begin
                    ev = 1; ec = ch; eb = b; want++;
                end
            end
        end
        fp = 1'b0;
        chk(seen == want, $sformatf("R10 %s strobe count act=%0d exp=%0d", tag, seen, want));
    endtask

    initial begin
        do_reset();
        // R10: no pulse, no strobe
        run_seq(0, 300, 0, 1, 12, NEVER, 0, 1, 12, 0, "R10 idle");
        // Vector table walk: R2 late point, R3 mid point, R7 long offsets
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            run_seq(3, 3 * FRAME + 200, VT[v][0], VT[v][1], VT[v][2],
                    NEVER, 0, 1, 12, v + 1,
                    (VT[v][2] > OVS) ? "R7" : (VT[v][1] != 0 ? "R2" : "R3"));
        end
        // R8/R9: mid-frame change to a longer offset
        do_reset();
        run_seq(4, 4 * FRAME + 200, 0, 1, 12, FRAME + 100, 4, 0, 24, 11, "R8 grow");
        // R8/R9: mid-frame change to a shorter offset, partial byte dropped
        do_reset();
        run_seq(4, 4 * FRAME + 200, 31, 1, 136, FRAME + 300, 0, 0, 8, 12, "R9 shrink");
        // R8: mode-only change mid-frame
        do_reset();
        run_seq(3, 3 * FRAME + 200, 5, 0, 28, FRAME + 7, 5, 1, 32, 13, "R8 mode");
        do_reset();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired act=timeout exp=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule